// File: doc/BRIEF.md
# Word and Split-Word Store Formatter

This block sits between the execute stage and the data-memory port of a 32-bit processor. For each store request it forms the effective address from a base register value and a sign-extended 16-bit displacement. It then puts a word-aligned address, per-byte write enables and lane-aligned write data on the memory port.

The block handles three stores. The full-word store needs an aligned address, and a misaligned one raises an address-error flag instead of writing. The left-half store writes the upper bytes of the source register, and the right-half store writes the lower bytes. For the two half stores, the low address bits decide which byte lanes are written. Because of this, a right-half store at address A followed by a left-half store at A+3 places a whole register into four consecutive bytes, even when those bytes cross a word boundary.

Memory is little-endian on the port. Byte enable bit j and data bits 8j+7:8j belong to the byte whose address ends in j. Each result is registered and appears one clock after the request.

Top module: `store_fmt_unit`

## Requirements
- R1: While reset is asserted, mem_wr, addr_err, mem_be, mem_addr and mem_wdata are all zero.
- R2: The effective address is base plus the 16-bit offset sign-extended to 32 bits. mem_addr is that address with bits 1:0 forced to zero.
- R3: Opcode 6'b101011 (full-word store) at an effective address with bits 1:0 equal to 0 gives mem_wr=1, mem_be=4'b1111 and mem_wdata equal to the source register.
- R4: Opcode 6'b101011 at an effective address with bits 1:0 not equal to 0 gives addr_err=1, mem_wr=0 and mem_be=0.
- R5: Opcode 6'b101010 (left-half store) at byte offset k enables lanes 0 through k. Lane j carries source byte 3-k+j, so the data equals the source shifted right by 8*(3-k). Unselected lanes carry zero.
- R6: Opcode 6'b101110 (right-half store) at byte offset k enables lanes k through 3. Lane j carries source byte j-k, so the data equals the source shifted left by 8*k.
- R7: The left-half and right-half stores never raise addr_err, at any offset.
- R8: Results appear on the clock edge after a cycle with req_valid=1. After a cycle with req_valid=0, mem_wr and addr_err are 0, and mem_addr and mem_wdata keep their values.
- R9: Any other opcode produces neither a write nor an error.
- R10: A right-half store at A followed by a left-half store at A+3 writes the source register into bytes A through A+3, with the least significant byte at A. Bytes outside that range are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A store request is present this cycle |
| req_op | input | 6 | Primary opcode of the request |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| src | input | 32 | Register value to be stored |
| mem_wr | output | 1 | Write strobe to memory |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| addr_err | output | 1 | Misaligned full-word store |

## Verification
Two outcomes of one request are judged in the same cycle. The write strobe and the address-error flag come from the same effective address, and the bench checks that a misaligned full-word store raises the error with no strobe and no byte enables. A second overlap is a new request arriving in the cycle in which the previous result is on the port. Back-to-back requests provoke this, and each cycle's output is compared against its own request. In particular, a right-half store and then a left-half store issued on consecutive cycles are applied to a small byte memory in the bench, and the four bytes that straddle the word boundary are compared with the source register.

// File: rtl/store_fmt_pkg.sv
`timescale 1ns/1ps
package store_fmt_pkg;
  localparam int OP_W = 6;
  localparam logic [OP_W-1:0] OPC_WORD  = 6'b101011;
  localparam logic [OP_W-1:0] OPC_LEFT  = 6'b101010;
  localparam logic [OP_W-1:0] OPC_RIGHT = 6'b101110;

  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_WORD  = 2'd1,
    ST_LEFT  = 2'd2,
    ST_RIGHT = 2'd3
  } st_kind_e;
endpackage

// File: rtl/sfu_op_decode.sv
`timescale 1ns/1ps
module sfu_op_decode
  import store_fmt_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output st_kind_e        kind
);
  always_comb begin
    unique case (op)
      OPC_WORD:  kind = ST_WORD;
      OPC_LEFT:  kind = ST_LEFT;
      OPC_RIGHT: kind = ST_RIGHT;
      default:   kind = ST_NONE;
    endcase
  end
endmodule

// File: rtl/sfu_ea_gen.sv
`timescale 1ns/1ps
module sfu_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LSB_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] ea_word,
  output logic [LSB_W-1:0]  lane_idx
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea       = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    ea_word  = {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
    lane_idx = ea[LSB_W-1:0];
  end
endmodule

// File: rtl/sfu_lane_shaper.sv
`timescale 1ns/1ps
module sfu_lane_shaper
  import store_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  st_kind_e          kind,
  input  logic [LSB_W-1:0]  lane_idx,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  lane_be,
  output logic [DATA_W-1:0] lane_data
);
  localparam logic [LSB_W-1:0] TOP_LANE = LSB_W'(LANES - 1);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [LSB_W-1:0] JL = LSB_W'(j);
    logic             sel;
    logic [LSB_W-1:0] pick;

    always_comb begin
      unique case (kind)
        ST_WORD: begin
          sel  = 1'b1;
          pick = JL;
        end
        ST_LEFT: begin
          sel  = (JL <= lane_idx);
          pick = JL + (TOP_LANE - lane_idx);
        end
        ST_RIGHT: begin
          sel  = (JL >= lane_idx);
          pick = JL - lane_idx;
        end
        default: begin
          sel  = 1'b0;
          pick = JL;
        end
      endcase
      lane_be[j]          = sel;
      lane_data[8*j +: 8] = sel ? src[{pick, 3'b000} +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/store_fmt_unit.sv
`timescale 1ns/1ps
module store_fmt_unit
  import store_fmt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] src,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              addr_err
);
  st_kind_e          kind;
  logic [ADDR_W-1:0] ea_word;
  logic [LSB_W-1:0]  lane_idx;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_data;

  logic              misalign;
  logic              wr_d, err_d;
  logic [LANES-1:0]  be_d;
  logic              wr_q, err_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  sfu_op_decode u_dec (
    .op   (req_op),
    .kind (kind)
  );

  sfu_ea_gen #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .LSB_W  (LSB_W)
  ) u_ea (
    .base     (base),
    .offset   (offset),
    .ea_word  (ea_word),
    .lane_idx (lane_idx)
  );

  sfu_lane_shaper #(
    .DATA_W (DATA_W)
  ) u_shape (
    .kind      (kind),
    .lane_idx  (lane_idx),
    .src       (src),
    .lane_be   (lane_be),
    .lane_data (lane_data)
  );

  // next-state
  always_comb begin
    misalign = (kind == ST_WORD) && (lane_idx != '0);
    wr_d     = req_valid && (kind != ST_NONE) && !misalign;
    err_d    = req_valid && misalign;
    be_d     = wr_d ? lane_be : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q  <= wr_d;
      err_q <= err_d;
      be_q  <= be_d;
      if (req_valid) begin
        addr_q <= ea_word;
        data_q <= lane_data;
      end
    end
  end

  assign mem_wr    = wr_q;
  assign addr_err  = err_q;
  assign mem_be    = be_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/sfu_checker.sv
`timescale 1ns/1ps
module sfu_checker
  import store_fmt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OP_W-1:0]   req_op,
  input logic [ADDR_W-1:0] base,
  input logic [OFF_W-1:0]  offset,
  input logic [DATA_W-1:0] src,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              addr_err
);
  logic [ADDR_W-1:0] sum_chk;
  logic              low_zero;
  logic              is_half;

  always_comb begin
    sum_chk  = base + ADDR_W'($signed(offset));
    low_zero = (sum_chk[LSB_W-1:0] == '0);
    is_half  = (req_op == OPC_LEFT) || (req_op == OPC_RIGHT);
  end

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mem_addr == {$past(sum_chk[ADDR_W-1:LSB_W]), {LSB_W{1'b0}}}); // R2

  AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_WORD && low_zero)
      |=> (mem_wr && mem_be == '1 && mem_wdata == $past(src))); // R3

  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_WORD && !low_zero)
      |=> (addr_err && !mem_wr && mem_be == '0)); // R4

  AST_WR_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && addr_err)); // R4

  AST_LEFT_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_LEFT) |=> (mem_wr && mem_be[0])); // R5

  AST_RIGHT_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_RIGHT) |=> (mem_wr && mem_be[LANES-1])); // R6

  AST_HALF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_half) |=> !addr_err); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_wr && !addr_err && $stable(mem_addr) && $stable(mem_wdata))); // R8

  AST_OTHER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != OPC_WORD && !is_half) |=> (!mem_wr && !addr_err)); // R9
endmodule

bind store_fmt_unit sfu_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W)
) u_sfu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .base      (base),
  .offset    (offset),
  .src       (src),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .addr_err  (addr_err)
);

// File: tb/tb_store_fmt_unit.sv
`timescale 1ns/1ps
module tb_store_fmt_unit;
  localparam logic [5:0] W = 6'b101011;
  localparam logic [5:0] L = 6'b101010;
  localparam logic [5:0] R = 6'b101110;
  localparam logic [5:0] X = 6'b100011;
  localparam int NV = 17;

  // {op, base, offset, src, wr, err, be, addr, data}
  localparam logic [155:0] VEC [NV] = '{
    {W, 32'h0000_1000, 16'h0004, 32'h1122_3344, 1'b1, 1'b0, 4'b1111, 32'h0000_1004, 32'h1122_3344},
    {W, 32'h0000_1000, 16'hFFFC, 32'h1122_3344, 1'b1, 1'b0, 4'b1111, 32'h0000_0FFC, 32'h1122_3344},
    {W, 32'h0000_1001, 16'h0000, 32'h1122_3344, 1'b0, 1'b1, 4'b0000, 32'h0000_1000, 32'h0000_0000},
    {W, 32'h0000_2000, 16'h0002, 32'h1122_3344, 1'b0, 1'b1, 4'b0000, 32'h0000_2000, 32'h0000_0000},
    {L, 32'h0000_3000, 16'h0000, 32'h1122_3344, 1'b1, 1'b0, 4'b0001, 32'h0000_3000, 32'h0000_0011},
    {L, 32'h0000_3000, 16'h0001, 32'h1122_3344, 1'b1, 1'b0, 4'b0011, 32'h0000_3000, 32'h0000_1122},
    {L, 32'h0000_3000, 16'h0002, 32'h1122_3344, 1'b1, 1'b0, 4'b0111, 32'h0000_3000, 32'h0011_2233},
    {L, 32'h0000_3000, 16'h0003, 32'h1122_3344, 1'b1, 1'b0, 4'b1111, 32'h0000_3000, 32'h1122_3344},
    {R, 32'h0000_3000, 16'h0000, 32'h1122_3344, 1'b1, 1'b0, 4'b1111, 32'h0000_3000, 32'h1122_3344},
    {R, 32'h0000_3000, 16'h0001, 32'h1122_3344, 1'b1, 1'b0, 4'b1110, 32'h0000_3000, 32'h2233_4400},
    {R, 32'h0000_3000, 16'h0002, 32'h1122_3344, 1'b1, 1'b0, 4'b1100, 32'h0000_3000, 32'h3344_0000},
    {R, 32'h0000_3000, 16'h0003, 32'h1122_3344, 1'b1, 1'b0, 4'b1000, 32'h0000_3000, 32'h4400_0000},
    {L, 32'h0000_4000, 16'hFFFF, 32'h1122_3344, 1'b1, 1'b0, 4'b1111, 32'h0000_3FFC, 32'h1122_3344},
    {X, 32'h0000_1000, 16'h0000, 32'h1122_3344, 1'b0, 1'b0, 4'b0000, 32'h0000_1000, 32'h0000_0000},
    {R, 32'h0000_5002, 16'hFFFD, 32'h1122_3344, 1'b1, 1'b0, 4'b1000, 32'h0000_4FFC, 32'h4400_0000},
    {R, 32'h0000_6001, 16'h0000, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'b1110, 32'h0000_6000, 32'hADBE_EF00},
    {L, 32'h0000_6002, 16'h0000, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'b0111, 32'h0000_6000, 32'h00DE_ADBE}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_op;
  logic [31:0] base;
  logic [15:0] offset;
  logic [31:0] src;
  logic        mem_wr;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        addr_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [7:0] bmem [0:31];

  store_fmt_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .base      (base),
    .offset    (offset),
    .src       (src),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .addr_err  (addr_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] s);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    base      = b;
    offset    = o;
    src       = s;
  endtask

  // apply the port's write to the byte memory at a negedge
  task automatic apply_mem();
    if (mem_wr) begin
      for (int j = 0; j < 4; j++) begin
        if (mem_be[j]) bmem[{mem_addr[4:2], 2'(j)}] = mem_wdata[8*j +: 8];
      end
    end
  endtask

  task automatic check_out_zero(input string tag);
    chk({tag, " wr"},   32'(mem_wr),   32'h0);
    chk({tag, " err"},  32'(addr_err), 32'h0);
    chk({tag, " be"},   32'(mem_be),   32'h0);
    chk({tag, " addr"}, mem_addr,      32'h0);
    chk({tag, " data"}, mem_wdata,     32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b1;
    req_valid = 1'b0;
    req_op    = '0;
    base      = '0;
    offset    = '0;
    src       = '0;
    for (int a = 0; a < 32; a++) bmem[a] = 8'h00;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_out_zero("R1 reset");
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [155:0] v;
      v = VEC[i];
      drive(v[155:150], v[149:118], v[117:102], v[101:70]);
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("vec%0d wr R3/R4/R9", i),  32'(mem_wr),   32'(v[69]));
      chk($sformatf("vec%0d err R4/R7", i),    32'(addr_err), 32'(v[68]));
      chk($sformatf("vec%0d be R5/R6", i),     32'(mem_be),   32'(v[67:64]));
      chk($sformatf("vec%0d addr R2", i),      mem_addr,      v[63:32]);
      if (v[69]) chk($sformatf("vec%0d data R5/R6", i), mem_wdata, v[31:0]);
    end

    // R8: idle cycle clears strobe, holds address and data
    drive(W, 32'h0000_7000, 16'h0008, 32'hCAFE_F00D);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 issue wr", 32'(mem_wr), 32'h1);
    @(negedge clk);
    chk("R8 idle wr",   32'(mem_wr),   32'h0);
    chk("R8 idle err",  32'(addr_err), 32'h0);
    chk("R8 hold addr", mem_addr,      32'h0000_7008);
    chk("R8 hold data", mem_wdata,     32'hCAFE_F00D);

    // R4 with R8: error request immediately followed by a good one
    drive(W, 32'h0000_7003, 16'h0000, 32'h0102_0304);
    drive(W, 32'h0000_7010, 16'h0000, 32'h0506_0708);
    chk("R4 b2b err", 32'(addr_err), 32'h1);
    chk("R4 b2b wr",  32'(mem_wr),   32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 b2b wr",   32'(mem_wr),   32'h1);
    chk("R8 b2b err",  32'(addr_err), 32'h0);
    chk("R8 b2b data", mem_wdata,     32'h0506_0708);

    // R10: right at A then left at A+3 on consecutive cycles, A = 0x0D
    drive(R, 32'h0000_000D, 16'h0000, 32'h1122_3344);
    drive(L, 32'h0000_000D, 16'h0003, 32'h1122_3344);
    apply_mem();
    @(negedge clk);
    req_valid = 1'b0;
    apply_mem();
    chk("R10 pairA byte0", 32'(bmem[13]), 32'h44);
    chk("R10 pairA byte1", 32'(bmem[14]), 32'h33);
    chk("R10 pairA byte2", 32'(bmem[15]), 32'h22);
    chk("R10 pairA byte3", 32'(bmem[16]), 32'h11);
    chk("R10 pairA below", 32'(bmem[12]), 32'h00);
    chk("R10 pairA above", 32'(bmem[17]), 32'h00);

    // R10: A = 0x17, right store touches one byte, left store three
    drive(R, 32'h0000_0017, 16'h0000, 32'hA1B2_C3D4);
    @(negedge clk);
    req_valid = 1'b0;
    apply_mem();
    drive(L, 32'h0000_0017, 16'h0003, 32'hA1B2_C3D4);
    @(negedge clk);
    req_valid = 1'b0;
    apply_mem();
    chk("R10 pairB byte0", 32'(bmem[23]), 32'hD4);
    chk("R10 pairB byte1", 32'(bmem[24]), 32'hC3);
    chk("R10 pairB byte2", 32'(bmem[25]), 32'hB2);
    chk("R10 pairB byte3", 32'(bmem[26]), 32'hA1);
    chk("R10 pairB below", 32'(bmem[22]), 32'h00);
    chk("R10 pairB above", 32'(bmem[27]), 32'h00);

    // R1: reset in mid-run clears a pending result
    drive(W, 32'h0000_1234, 16'h0000, 32'h5555_AAAA);
    @(negedge clk);
    req_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1 check_out_zero("R1 midrun");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule